// File: doc/BRIEF.md
# NAND Read/Write Strobe Timing Generator

This block drives the strobes of one asynchronous single-data-rate NAND flash bus cycle. A one-cycle command asks for either a single write cycle or a single read cycle. The block then walks through a fixed order of phases. Each phase lasts a cycle count taken from two 32-bit timing words. It drives the active-low write and read strobes and the data-output enable, latches the read byte at the access point, and signals completion with a one-clock pulse.

Both timing words hold four byte-wide counts. Each count is the number of controller clocks, rounded up, that covers one datasheet interval; software does that rounding before it writes the words. The write low time is not stored directly. It is the write-cycle count minus the write-high count. The ready/busy line of the flash is registered once and brought out as a plain output.

Top module: `nand_strobe_gen`

## Requirements
- R1: While reset is asserted and after its release with no command, we_n and re_n are 1, dq_oe, done and busy are 0.
- R2: Write timing word tim_wr: bits [31:24] ready delay, [23:16] write extend, [15:8] write cycle, [7:0] write high. A write command accepted at edge E drives we_n low from E for (write cycle - write high) clocks, or 1 clock if write cycle is not larger than write high. It then holds we_n high for the write-high count, then waits the write-extend count.
- R3: Read timing word tim_rd: bits [31:24] access, [23:16] hold, [15:8] read pulse, [7:0] read extend. A read command accepted at edge E keeps re_n high for the ready-delay count, drives re_n low for the read-pulse count, then holds it high for the hold count, then waits the read-extend count.
- R4: Any count field of value 0 lasts one clock, exactly as a value of 1 does.
- R5: rd_data takes dq_in on the edge that ends the access-count-th clock after re_n fell. If that edge lies beyond the end of the extend phase, the extend phase is stretched until that edge.
- R6: done is high for exactly one clock, the clock after the last phase. busy is high from the edge that accepts a command through the done clock, and low again on the next clock.
- R7: cmd_valid while busy is 1 is ignored; the running cycle's strobe counts, done time and data are unchanged, and no second cycle follows.
- R8: dq_oe is high exactly while a write is in its low or high phase. During that time, dq_out holds the wr_data value present at the accepting edge, even if wr_data changes afterwards.
- R9: ready equals the value rb_n had one clock earlier.
- R10: we_n stays 1 for a whole read cycle and re_n stays 1 for a whole write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_wr | input | 32 | Write-side timing word; must stay stable while busy |
| tim_rd | input | 32 | Read-side timing word; must stay stable while busy |
| cmd_valid | input | 1 | One-clock request for a bus cycle |
| cmd_is_read | input | 1 | 1 selects a read cycle, 0 a write cycle |
| wr_data | input | 8 | Byte to drive during a write |
| dq_in | input | 8 | Byte from the flash data bus |
| rb_n | input | 1 | Flash ready/busy line |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Byte driven onto the data bus |
| dq_oe | output | 1 | Data-output enable |
| rd_data | output | 8 | Byte latched at the access point |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | A bus cycle is in progress |
| ready | output | 1 | Registered ready/busy line |

## Verification
Writes are run with a write cycle larger than the high count, with a write cycle smaller than the high count, and with all fields zero. These runs separate the subtract path, the one-clock floor and the zero-as-one rule. Reads are run with the access point inside the low pulse, with the access point well past the extend phase, and with all fields zero. The bench drives a byte on the data bus that changes every clock, so the latched value shows on which edge the capture happened and whether the extend phase was stretched. A second command injected mid-cycle, and a wr_data change after acceptance, show that a running cycle cannot be disturbed.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;
  localparam int CW = 8;
  localparam int WORD_W = 4 * CW;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WLOW, ST_WHIGH, ST_WEXT,
    ST_RRDY, ST_RLOW, ST_RHOLD, ST_REXT, ST_DONE
  } phase_e;

  typedef struct packed {
    logic [CW-1:0] rdy;
    logic [CW-1:0] wext;
    logic [CW-1:0] wlow;
    logic [CW-1:0] whigh;
    logic [CW-1:0] acc;
    logic [CW-1:0] hold;
    logic [CW-1:0] rpulse;
    logic [CW-1:0] rext;
  } phase_cnts_t;
endpackage

// File: rtl/nand_tim_decode.sv
module nand_tim_decode
  import nand_strobe_pkg::*;
(
  input  logic [WORD_W-1:0] tim_wr,
  input  logic [WORD_W-1:0] tim_rd,
  output phase_cnts_t       cnts
);
  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  logic [CW-1:0] wc_raw, wh_raw;

  always_comb begin
    wc_raw      = tim_wr[2*CW-1:CW];
    wh_raw      = tim_wr[CW-1:0];
    cnts.rdy    = at_least_one(tim_wr[4*CW-1:3*CW]);
    cnts.wext   = at_least_one(tim_wr[3*CW-1:2*CW]);
    cnts.whigh  = at_least_one(wh_raw);
    cnts.wlow   = (wc_raw > wh_raw) ? (wc_raw - wh_raw) : CW'(1);
    cnts.acc    = at_least_one(tim_rd[4*CW-1:3*CW]);
    cnts.hold   = at_least_one(tim_rd[3*CW-1:2*CW]);
    cnts.rpulse = at_least_one(tim_rd[2*CW-1:CW]);
    cnts.rext   = at_least_one(tim_rd[CW-1:0]);
  end
endmodule

// File: rtl/nand_phase_cnt.sv
module nand_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/nand_strobe_fsm.sv
module nand_strobe_fsm
  import nand_strobe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_is_read,
  input  phase_cnts_t   cnts,
  input  logic          ph_zero,
  input  logic          acc_zero,
  output phase_e        st_q,
  output logic          accept,
  output logic          ph_load,
  output logic [CW-1:0] ph_val,
  output logic          acc_load,
  output logic [CW-1:0] acc_val,
  output logic          capture,
  output logic          done,
  output logic          busy
);
  phase_e st_d;
  logic   acc_pend_q, acc_pend_d;
  logic   in_read_tail;

  always_comb begin
    in_read_tail = (st_q == ST_RLOW) || (st_q == ST_RHOLD) || (st_q == ST_REXT);
    capture      = acc_pend_q && acc_zero && in_read_tail;
    accept       = (st_q == ST_IDLE) && cmd_valid;
    st_d         = st_q;
    unique case (st_q)
      ST_IDLE:  if (cmd_valid) st_d = cmd_is_read ? ST_RRDY : ST_WLOW;
      ST_WLOW:  if (ph_zero) st_d = ST_WHIGH;
      ST_WHIGH: if (ph_zero) st_d = ST_WEXT;
      ST_WEXT:  if (ph_zero) st_d = ST_DONE;
      ST_RRDY:  if (ph_zero) st_d = ST_RLOW;
      ST_RLOW:  if (ph_zero) st_d = ST_RHOLD;
      ST_RHOLD: if (ph_zero) st_d = ST_REXT;
      ST_REXT:  if (ph_zero && (!acc_pend_q || capture)) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase

    ph_load = (st_d != st_q);
    unique case (st_d)
      ST_WLOW:  ph_val = cnts.wlow - CW'(1);
      ST_WHIGH: ph_val = cnts.whigh - CW'(1);
      ST_WEXT:  ph_val = cnts.wext - CW'(1);
      ST_RRDY:  ph_val = cnts.rdy - CW'(1);
      ST_RLOW:  ph_val = cnts.rpulse - CW'(1);
      ST_RHOLD: ph_val = cnts.hold - CW'(1);
      ST_REXT:  ph_val = cnts.rext - CW'(1);
      default:  ph_val = '0;
    endcase

    acc_load   = (st_d == ST_RLOW) && (st_q != ST_RLOW);
    acc_val    = cnts.acc - CW'(1);
    acc_pend_d = acc_load ? 1'b1 : (capture ? 1'b0 : acc_pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      acc_pend_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      acc_pend_q <= acc_pend_d;
    end
  end

  assign done = (st_q == ST_DONE);
  assign busy = (st_q != ST_IDLE);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R5
  capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !acc_pend_q);
  // R5
  no_done_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !acc_pend_q);
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tim_wr,
  input  logic [31:0] tim_rd,
  input  logic        cmd_valid,
  input  logic        cmd_is_read,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  dq_in,
  input  logic        rb_n,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  dq_out,
  output logic        dq_oe,
  output logic [7:0]  rd_data,
  output logic        done,
  output logic        busy,
  output logic        ready
);
  phase_cnts_t   cnts;
  phase_e        st;
  logic          accept, ph_load, acc_load, capture, ph_zero, acc_zero;
  logic [CW-1:0] ph_val, acc_val;
  logic [CW-1:0] wr_q, rd_q;
  logic          rdy_q;

  nand_tim_decode u_dec (.tim_wr(tim_wr), .tim_rd(tim_rd), .cnts(cnts));

  nand_phase_cnt #(.W(CW)) u_ph_cnt (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero));

  nand_phase_cnt #(.W(CW)) u_acc_cnt (
    .clk(clk), .rst_n(rst_n), .load(acc_load), .load_val(acc_val), .zero(acc_zero));

  nand_strobe_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
    .cnts(cnts), .ph_zero(ph_zero), .acc_zero(acc_zero), .st_q(st),
    .accept(accept), .ph_load(ph_load), .ph_val(ph_val), .acc_load(acc_load),
    .acc_val(acc_val), .capture(capture), .done(done), .busy(busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (accept)  wr_q <= wr_data;
      if (capture) rd_q <= dq_in;
      rdy_q <= rb_n;
    end
  end

  assign we_n    = (st != ST_WLOW);
  assign re_n    = (st != ST_RLOW);
  assign dq_oe   = (st == ST_WLOW) || (st == ST_WHIGH);
  assign dq_out  = wr_q;
  assign rd_data = rd_q;
  assign ready   = rdy_q;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R8
  oe_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));
  // R10
  oe_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> re_n);
endmodule

// File: tb/nand_strobe_gen_tb.sv
module nand_strobe_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tim_wr = '0, tim_rd = '0;
  logic        cmd_valid = 1'b0, cmd_is_read = 1'b0;
  logic [7:0]  wr_data = '0, dq_in = '0;
  logic        rb_n = 1'b0;
  logic        we_n, re_n, dq_oe, done, busy, ready;
  logic [7:0]  dq_out, rd_data;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  nand_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tim_wr(tim_wr), .tim_rd(tim_rd),
    .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read), .wr_data(wr_data),
    .dq_in(dq_in), .rb_n(rb_n), .we_n(we_n), .re_n(re_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .rd_data(rd_data), .done(done), .busy(busy), .ready(ready));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nz(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // One bus cycle; expectations derived from the field rules of R2..R5.
  task automatic run_op(input string name, input bit rd, input logic [31:0] ww,
                        input logic [31:0] rw, input logic [7:0] wd,
                        input logic [7:0] base, input bit inject);
    int l_w, h_w, x_w, r_d, p_r, hd, x_r, a_c, tail, exp_done;
    int we_cnt = 0, re_cnt = 0, oe_cnt = 0, oe_bad = 0, busy_cnt = 0;
    int first_re = 0, done_at = 0;
    l_w = (int'(ww[15:8]) > int'(ww[7:0])) ? int'(ww[15:8]) - int'(ww[7:0]) : 1;
    h_w = nz(int'(ww[7:0]));
    x_w = nz(int'(ww[23:16]));
    r_d = nz(int'(ww[31:24]));
    a_c = nz(int'(rw[31:24]));
    hd  = nz(int'(rw[23:16]));
    p_r = nz(int'(rw[15:8]));
    x_r = nz(int'(rw[7:0]));
    tail = (p_r + hd + x_r > a_c) ? p_r + hd + x_r : a_c;
    exp_done = rd ? r_d + tail + 1 : l_w + h_w + x_w + 1;
    tim_wr = ww; tim_rd = rw; wr_data = wd; dq_in = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = rd;
    for (int n = 1; n <= 1000; n++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (n == 1) wr_data = ~wd;
      if (inject && n == 2) begin cmd_valid = 1'b1; cmd_is_read = !rd; end
      if (!we_n) we_cnt++;
      if (!re_n) re_cnt++;
      if (busy) busy_cnt++;
      if (dq_oe) begin
        oe_cnt++;
        if (dq_out != wd) oe_bad++;
      end
      if (!re_n && first_re == 0) first_re = n;
      if (first_re != 0) dq_in = base + 8'(n - first_re + 1);
      if (done) begin done_at = n; break; end
    end
    chk({name, " R6 done index"}, done_at, exp_done);
    chk({name, " R6 busy clocks"}, busy_cnt, exp_done);
    if (rd) begin
      chk({name, " R3 re_n first low"}, first_re, r_d + 1);
      chk({name, " R3 re_n low clocks"}, re_cnt, p_r);
      chk({name, " R10 we_n in read"}, we_cnt, 0);
      chk({name, " R5 rd_data"}, int'(rd_data), int'(base + 8'(a_c)));
      chk({name, " R8 oe in read"}, oe_cnt, 0);
    end else begin
      chk({name, " R2 we_n low clocks"}, we_cnt, l_w);
      chk({name, " R8 oe clocks"}, oe_cnt, l_w + h_w);
      chk({name, " R8 dq_out held"}, oe_bad, 0);
      chk({name, " R10 re_n in write"}, re_cnt, 0);
    end
    @(negedge clk);
    chk({name, " R6 done one clock"}, int'(done), 0);
    chk({name, " R7 idle after done"}, int'(busy), 0);
    repeat (3) @(negedge clk);
    chk({name, " R7 no second cycle"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk("R1 we_n reset", int'(we_n), 1);
    chk("R1 re_n reset", int'(re_n), 1);
    chk("R1 oe/done/busy reset", int'({dq_oe, done, busy}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", int'({we_n, re_n, dq_oe, done, busy}), 5'b11000);
  endtask

  task automatic t_ready();
    for (int i = 0; i < 6; i++) begin
      logic v;
      v = i[0] ^ i[1];
      rb_n = v;
      @(negedge clk);
      chk("R9 ready lags rb_n", int'(ready), int'(v));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_op("wr_typ",   1'b0, 32'h03_02_05_02, 32'h0, 8'hA5, 8'h00, 1'b0);
    run_op("wr_floor", 1'b0, 32'h00_00_01_04, 32'h0, 8'h3C, 8'h00, 1'b0); // R2 R4
    run_op("wr_zero",  1'b0, 32'h0,           32'h0, 8'h5A, 8'h00, 1'b0); // R4
    run_op("rd_typ",   1'b1, 32'h03_00_00_00, 32'h02_02_04_01, 8'h00, 8'h40, 1'b0);
    run_op("rd_late",  1'b1, 32'h02_00_00_00, 32'h09_01_02_01, 8'h00, 8'h80, 1'b0); // R5
    run_op("rd_zero",  1'b1, 32'h0,           32'h0, 8'h00, 8'h20, 1'b0); // R4
    run_op("wr_inj",   1'b0, 32'h01_03_06_02, 32'h0, 8'hC3, 8'h00, 1'b1); // R7
    run_op("rd_inj",   1'b1, 32'h02_00_00_00, 32'h03_02_05_02, 8'h00, 8'h10, 1'b1); // R7
    t_ready();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule